// File: doc/BRIEF.md
# Five-Write Serial Register Loader

This block sits on the CPU write path of a cartridge controller and builds 5-bit control registers from single bits. Each write moves bit 0 of the data byte into a shift register. The first write lands in bit 0 and each later write lands one position higher. When the fifth bit arrives, the assembled value is stored in one of four registers. Address bits 14:13 of that fifth write choose the register.

Two events throw away a partial sequence. The first is a write with data bit 7 set. The second is a write whose register select differs from the select of the write before it. After either event the collection starts again from bit 0.

Register 0 controls nametable mirroring, and the block decodes its low two bits into a mirroring code. Registers 1 to 3 leave the block as raw 5-bit values for a downstream bank decoder. Every store also raises a one-cycle commit pulse, which carries the index of the register that was loaded.

Top module: `serial_reg_loader`

## Requirements
- R1: A write with data bit 7 set clears the partial shift state and the write count. It stores nothing, raises no commit pulse and leaves all four registers unchanged.
- R2: Bits assemble LSB first. The data bit 0 of the k-th accepted write of a sequence (k = 1..5) becomes bit k-1 of the stored value.
- R3: The fifth accepted write of a sequence stores the 5-bit value into the register numbered by address bits 14:13 (0..3). The loader then starts empty.
- R4: If a write's address bits 14:13 differ from those of the previous write, the partial state clears before that write's bit is taken. That bit then counts as bit 0. Every write updates the remembered select, including writes with bit 7 set.
- R5: The mirroring output decodes register 0 bits 1:0 as follows: 2'b00 is single-screen page 0 (code 0), 2'b01 is single-screen page 1 (code 1), 2'b10 is vertical (code 2) and 2'b11 is horizontal (code 3).
- R6: Timing of a store. The clock edge that samples the storing write updates the register and raises the commit pulse. The commit pulse stays high for exactly one cycle, and the index output carries the register number.
- R7: After reset, register 0 holds 0x0C, registers 1 to 3 hold 0, the mirroring code is 0, the commit pulse is low and the loader is empty.
- R8: A cycle with the write strobe low changes no register and no loader state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | Write address; bits 14:13 select the register |
| wr_data | input | 8 | Write data; bit 0 is the serial bit, bit 7 is the loader reset |
| reg0 | output | 5 | Register 0, the mirroring control |
| reg1 | output | 5 | Register 1, raw value for the bank decoder |
| reg2 | output | 5 | Register 2, raw value for the bank decoder |
| reg3 | output | 5 | Register 3, raw value for the bank decoder |
| mirror_mode | output | 2 | Decoded mirroring code |
| commit_pulse | output | 1 | One-cycle pulse when a register is stored |
| commit_index | output | 2 | Index of the register just stored |

## Verification
Two functions of the block can fall on the same write: a change of register select and the step that would complete a sequence. The bench provokes this with four writes to one register followed by a write to another register. If the clear from the select change were ordered after the count check, that write would store a value in the wrong register. The bench judges the write against its own model, which expects no commit pulse, a loader count of one and unchanged registers. The bench also sends bit-7 writes carrying a select change into random streams, and it checks that the next accepted bit still lands in bit 0.

// File: rtl/loader_pkg.sv
package loader_pkg;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  function automatic mirror_e decode_mirror(input logic [1:0] ctl);
    mirror_e m;
    if (ctl[1]) m = ctl[0] ? MIR_HORZ : MIR_VERT;
    else        m = ctl[0] ? MIR_ONE_HI : MIR_ONE_LO;
    return m;
  endfunction

endpackage

// File: rtl/shift_collector.sv
module shift_collector #(
  parameter int SHIFT_W = 5,
  parameter int SEL_W   = 2,
  localparam int CNT_W  = (SHIFT_W > 1) ? $clog2(SHIFT_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               data_bit,
  input  logic               clear_bit,
  output logic               commit_evt,
  output logic [SEL_W-1:0]   commit_sel,
  output logic [SHIFT_W-1:0] commit_val,
  output logic [CNT_W-1:0]   count_q,
  output logic               sel_switch
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_W - 1);

  logic [CNT_W-1:0]   cnt_q, base_cnt;
  logic [SHIFT_W-1:0] shift_q, base_shift, assembled;
  logic [SEL_W-1:0]   prev_q;
  logic               take;

  always_comb begin
    sel_switch = wr_en && (sel != prev_q);
    base_cnt   = sel_switch ? '0 : cnt_q;
    base_shift = sel_switch ? '0 : shift_q;
    assembled  = base_shift;
    for (int i = 0; i < SHIFT_W; i++)
      if (base_cnt == CNT_W'(i)) assembled[i] = data_bit;
    take       = wr_en && !clear_bit;
    commit_evt = take && (base_cnt == LAST);
    commit_sel = sel;
    commit_val = assembled;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
      prev_q  <= '0;
    end else if (wr_en) begin
      prev_q <= sel;
      if (clear_bit || commit_evt) begin
        cnt_q   <= '0;
        shift_q <= '0;
      end else begin
        cnt_q   <= base_cnt + CNT_W'(1);
        shift_q <= assembled;
      end
    end
  end

  assign count_q = cnt_q;

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int REG_W    = 5,
  parameter int IDX_W    = 2,
  parameter logic [REG_W-1:0] RESET0 = 5'h0C,
  localparam int NUM_REGS = 1 << IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [IDX_W-1:0]               load_idx,
  input  logic [REG_W-1:0]               load_val,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs,
  output logic                           pulse_q,
  output logic [IDX_W-1:0]               idx_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [REG_W-1:0] RST_VAL = (g == 0) ? RESET0 : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  regs[g] <= RST_VAL;
      else if (load && (load_idx == IDX_W'(g)))    regs[g] <= load_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      pulse_q <= load;
      if (load) idx_q <= load_idx;
    end
  end

endmodule

// File: rtl/mirror_decode.sv
module mirror_decode
  import loader_pkg::*;
(
  input  logic [1:0] ctl,
  output logic [1:0] mode
);
  mirror_e m;
  always_comb begin
    m    = decode_mirror(ctl);
    mode = m;
  end
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_LO = 13,
  parameter int SHIFT_W = 5,
  parameter logic [SHIFT_W-1:0] RESET0 = 5'h0C,
  localparam int SEL_W = 2,
  localparam int NUM_REGS = 1 << SEL_W,
  localparam int CNT_W = (SHIFT_W > 1) ? $clog2(SHIFT_W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [SHIFT_W-1:0] reg0,
  output logic [SHIFT_W-1:0] reg1,
  output logic [SHIFT_W-1:0] reg2,
  output logic [SHIFT_W-1:0] reg3,
  output logic [1:0]         mirror_mode,
  output logic               commit_pulse,
  output logic [SEL_W-1:0]   commit_index
);
  logic [SEL_W-1:0]   wr_sel;
  logic               clear_bit;
  logic               commit_evt;
  logic [SEL_W-1:0]   commit_sel;
  logic [SHIFT_W-1:0] commit_val;
  logic [CNT_W-1:0]   count_q;
  logic               sel_switch;
  logic [NUM_REGS-1:0][SHIFT_W-1:0] regs;

  assign wr_sel    = wr_addr[SEL_LO +: SEL_W];
  assign clear_bit = wr_data[DATA_W-1];

  shift_collector #(.SHIFT_W(SHIFT_W), .SEL_W(SEL_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(wr_sel),
    .data_bit(wr_data[0]), .clear_bit(clear_bit),
    .commit_evt(commit_evt), .commit_sel(commit_sel), .commit_val(commit_val),
    .count_q(count_q), .sel_switch(sel_switch)
  );

  reg_bank #(.REG_W(SHIFT_W), .IDX_W(SEL_W), .RESET0(RESET0)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(commit_evt), .load_idx(commit_sel),
    .load_val(commit_val), .regs(regs), .pulse_q(commit_pulse),
    .idx_q(commit_index)
  );

  mirror_decode u_mirror (.ctl(regs[0][1:0]), .mode(mirror_mode));

  assign reg0 = regs[0];
  assign reg1 = regs[1];
  assign reg2 = regs[2];
  assign reg3 = regs[3];

endmodule

// File: rtl/serial_reg_loader_chk.sv
module serial_reg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       clear_bit,
  input logic [2:0] count_q,
  input logic       sel_switch,
  input logic       commit_pulse,
  input logic [1:0] commit_index,
  input logic [19:0] all_regs
);
  AST_CLEAR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && clear_bit) |=> (!commit_pulse && count_q == 3'd0)); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= 3'd4); // R2
  AST_COMMIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> (commit_index == $past(wr_sel) && count_q == 3'd0)); // R3
  AST_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_switch && !clear_bit) |=> (count_q == 3'd1 && !commit_pulse)); // R4
  AST_COMMIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> ($past(wr_en) && !$past(clear_bit))); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(all_regs) && $stable(count_q) && !commit_pulse)); // R8
endmodule

bind serial_reg_loader serial_reg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .clear_bit(clear_bit), .count_q(count_q), .sel_switch(sel_switch),
  .commit_pulse(commit_pulse), .commit_index(commit_index),
  .all_regs({reg3, reg2, reg1, reg0})
);

// File: tb/sim_serial_reg_loader.sv
`timescale 1ns/100ps
module sim_serial_reg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [4:0] reg0, reg1, reg2, reg3;
  logic [1:0] mirror_mode;
  logic commit_pulse;
  logic [1:0] commit_index;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [4:0] m_regs [4];
  int         m_cnt;
  logic [4:0] m_shift;
  logic [1:0] m_prev;
  bit         m_commit;
  logic [1:0] m_idx;

  always #2.5 clk = ~clk;

  serial_reg_loader u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .reg0(reg0), .reg1(reg1), .reg2(reg2), .reg3(reg3),
    .mirror_mode(mirror_mode), .commit_pulse(commit_pulse),
    .commit_index(commit_index)
  );

  function automatic int exp_mirror(logic [4:0] r);
    if (r[1] == 1'b1) return (r[0] == 1'b1) ? 3 : 2;
    return (r[0] == 1'b1) ? 1 : 0;
  endfunction

  function automatic logic [15:0] mk_addr(int sel, int low);
    return 16'h8000 | 16'((sel & 3) << 13) | 16'(low & 16'h1FFF);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    logic [1:0] s = a[14:13];
    m_commit = 0;
    if (s != m_prev) begin m_cnt = 0; m_shift = 0; end
    m_prev = s;
    if (d[7]) begin
      m_cnt = 0; m_shift = 0;
    end else begin
      m_shift[m_cnt] = d[0];
      if (m_cnt == 4) begin
        m_regs[s] = m_shift; m_commit = 1; m_idx = s;
        m_cnt = 0; m_shift = 0;
      end else m_cnt++;
    end
  endtask

  task automatic check_outputs(string tag);
    chk({tag, " R3 reg0"}, reg0, m_regs[0]);
    chk({tag, " R3 reg1"}, reg1, m_regs[1]);
    chk({tag, " R3 reg2"}, reg2, m_regs[2]);
    chk({tag, " R3 reg3"}, reg3, m_regs[3]);
    chk({tag, " R5 mirror"}, mirror_mode, exp_mirror(m_regs[0]));
    chk({tag, " R6 pulse"}, commit_pulse, m_commit);
    if (m_commit) chk({tag, " R6 index"}, commit_index, m_idx);
  endtask

  // called at a negedge; returns at the negedge after the write's edge
  task automatic do_write(string tag, logic [15:0] a, logic [7:0] d, bit idle);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_outputs(tag);
    if (idle) begin
      m_commit = 0;
      @(negedge clk);
      check_outputs({tag, " R8 idle"});
    end
  endtask

  task automatic send5(string tag, int sel, logic [4:0] v);
    for (int i = 0; i < 5; i++)
      do_write(tag, mk_addr(sel, i * 7), {7'd0, v[i]}, 1'b0);
  endtask

  initial begin
    m_regs[0] = 5'h0C; m_regs[1] = 0; m_regs[2] = 0; m_regs[3] = 0;
    m_cnt = 0; m_shift = 0; m_prev = 0; m_commit = 0; m_idx = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R7 reset");
    chk("R7 reset mirror code", mirror_mode, 0);

    // R2: LSB-first, value 0b01101 into register 1
    send5("R2 lsb first", 1, 5'b01101);
    chk("R2 reg1 value", reg1, 5'h0D);
    @(negedge clk);
    m_commit = 0;
    check_outputs("R6 one cycle");

    // R1: bit-7 write mid sequence discards partial state
    for (int i = 0; i < 3; i++) do_write("R1 partial", mk_addr(2, 0), 8'h01, 1'b0);
    do_write("R1 clear", mk_addr(2, 0), 8'h80, 1'b0);
    send5("R1 after clear", 2, 5'b10010);
    chk("R1 reg2 value", reg2, 5'h12);

    // R4: select switch on what would be the fifth write
    for (int i = 0; i < 4; i++) do_write("R4 four", mk_addr(3, 0), 8'h01, 1'b0);
    do_write("R4 switch", mk_addr(1, 0), 8'h01, 1'b0);
    chk("R4 no commit on switch", commit_pulse, 0);
    for (int i = 0; i < 4; i++) do_write("R4 rest", mk_addr(1, 0), 8'h00, 1'b0);
    chk("R4 reg1 restarted", reg1, 5'h01);
    chk("R4 reg3 untouched", reg3, 5'h00);

    // R5: all mirroring modes via register 0
    for (int m = 0; m < 4; m++) begin
      send5("R5 mode", 0, 5'(m) | 5'h14);
      chk("R5 mirror code", mirror_mode, m);
    end

    // random stream
    for (int n = 0; n < 800; n++) begin
      int sel = ($urandom % 8 == 0) ? int'($urandom % 4) : int'(m_prev);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 10 != 0) d[7] = 1'b0;
      do_write("rand", mk_addr(sel, int'($urandom)), d, ($urandom % 4 == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule